// File: doc/BRIEF.md
# Key-Protected Configuration Register Bank

A small bank of system configuration registers on a plain 32-bit register bus (address, write strobe, write data, read strobe, read data). Out of reset, every register can be read but none of the protected ones can be changed. Software opens the bank by writing two fixed 32-bit key words, one into each of two key registers, in either order. Any other value written to either key register shuts the bank again and discards both key matches. The keys themselves always read back as zero.

The bank holds a group of general-purpose 32-bit configuration words, a suspend-source register with four writable bits, and a read-only boot-configuration register. The boot register samples the external boot-select pins on every clock while reset is held and freezes the last sample when reset is released. A write to a protected register while the bank is locked is dropped without effect. When the error option is on, that dropped write also raises a one-cycle error pulse. The bus has no back-pressure: the bank accepts every access in the cycle it is presented, so there is no valid/ready pair at its edge.

Top module: `keyed_cfg_bank`

## Requirements
- R1: While `rst_n` is low at a clock edge, the bank becomes locked, every general-purpose word becomes 0 and the suspend register becomes 0x08510000.
- R2: The first key register at byte offset 0x038 must receive 0x83E70B13 and the second at 0x03C must receive 0x95A4F1E0, in either order. Once both match, a protected write in the next cycle takes effect.
- R3: A write to a protected register (general-purpose words or suspend register) while locked leaves the register unchanged.
- R4: A write of any non-key value to either key register locks the bank and clears both key matches, so a later single correct key does not unlock.
- R5: Reads of offsets 0x038 and 0x03C always return 0.
- R6: The boot register at offset 0x020 returns the pin value present at the last clock edge with `rst_n` low, zero-extended. It ignores pin changes and bus writes until the next reset.
- R7: The suspend register at offset 0x170 stores only bits 16, 20, 22 and 27 of the write data. All its other bits read 0.
- R8: General-purpose word i sits at byte offset 0x100 + 4*i, for i below NUM_GP. All 32 bits are writable once the bank is unlocked.
- R9: Any offset not listed above, including unaligned ones, reads as 0, and writes to it change nothing.
- R10: `bus_rdata` takes the addressed value at the clock edge where `bus_rd` is high. It holds that value until the next read.
- R11: With ERR_EN=1, `wr_blocked` is high for the one cycle after a write to a protected register while locked. It stays low after any other write, including key writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all logic on rising edge |
| rst_n | input | 1 | Synchronous active-low reset; boot pins are sampled while low |
| boot_pins | input | BOOT_W | External boot-select pins |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one write per cycle high |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, one cycle after the read strobe |
| wr_blocked | output | 1 | One-cycle pulse for a write dropped by the lock |

## Verification
The bench builds the bank with four general-purpose words and an 8-bit boot field, with the error pulse enabled. This keeps every mapped register reachable in a few hundred random accesses. With the narrow boot field, an inverted pin pattern after release is enough to show whether the capture froze. Random key writes, about half of them correct, push the lock through every pair of key-match states. Directed sequences then cover both unlock orders, a relock after a wrong key, and a reset applied while the bank is open.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;
  localparam int unsigned DW = 32;

  localparam logic [DW-1:0] KEY_A_VAL = 32'h83E7_0B13;
  localparam logic [DW-1:0] KEY_B_VAL = 32'h95A4_F1E0;

  localparam int unsigned OFS_KEY_A = 'h038;
  localparam int unsigned OFS_KEY_B = 'h03C;
  localparam int unsigned OFS_BOOT  = 'h020;
  localparam int unsigned OFS_SUSP  = 'h170;
  localparam int unsigned OFS_GP    = 'h100;

  // bits 16, 20, 22, 27 are the only stored suspend-source bits
  localparam logic [DW-1:0] SUSP_MASK = 32'h0851_0000;
  localparam logic [DW-1:0] SUSP_RST  = SUSP_MASK;

  typedef struct packed {
    logic key_a;
    logic key_b;
    logic boot;
    logic susp;
  } fixed_sel_t;
endpackage

// File: rtl/cfg_key_lock.sv
module cfg_key_lock
  import cfgbank_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_key_a,
  input  logic          wr_key_b,
  input  logic [DW-1:0] wdata,
  output logic          unlocked
);
  logic a_ok, b_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_ok <= 1'b0;
      b_ok <= 1'b0;
    end else if (wr_key_a) begin
      if (wdata == KEY_A_VAL) a_ok <= 1'b1;
      else begin
        a_ok <= 1'b0;
        b_ok <= 1'b0;
      end
    end else if (wr_key_b) begin
      if (wdata == KEY_B_VAL) b_ok <= 1'b1;
      else begin
        a_ok <= 1'b0;
        b_ok <= 1'b0;
      end
    end
  end

  assign unlocked = a_ok & b_ok;
endmodule

// File: rtl/cfg_boot_latch.sv
module cfg_boot_latch #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins,
  output logic [W-1:0] boot_q
);
  // follows the pins while reset is held, frozen after release
  always_ff @(posedge clk) begin
    if (!rst_n) boot_q <= pins;
  end
endmodule

// File: rtl/cfg_reg_store.sv
module cfg_reg_store
  import cfgbank_pkg::*;
#(
  parameter int unsigned NUM_GP = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_ok,
  input  logic [NUM_GP-1:0]          sel_gp,
  input  logic                       sel_susp,
  input  logic [DW-1:0]              wdata,
  output logic [NUM_GP-1:0][DW-1:0]  gp_q,
  output logic [DW-1:0]              susp_q
);
  for (genvar i = 0; i < NUM_GP; i++) begin : g_gp
    always_ff @(posedge clk) begin
      if (!rst_n)                 gp_q[i] <= '0;
      else if (wr_ok && sel_gp[i]) gp_q[i] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 susp_q <= SUSP_RST;
    else if (wr_ok && sel_susp) susp_q <= wdata & SUSP_MASK;
  end
endmodule

// File: rtl/keyed_cfg_bank.sv
module keyed_cfg_bank
  import cfgbank_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned NUM_GP = 4,
  parameter int unsigned BOOT_W = 16,
  parameter bit          ERR_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BOOT_W-1:0] boot_pins,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              bus_rd,
  output logic [DW-1:0]     bus_rdata,
  output logic              wr_blocked
);
  localparam int unsigned GP_END = OFS_GP + 4 * NUM_GP;

  initial begin
    if (GP_END > OFS_SUSP || NUM_GP == 0 || BOOT_W > DW || (1 << ADDR_W) <= OFS_SUSP)
      $error("keyed_cfg_bank: parameter set does not fit the map");
  end

  fixed_sel_t               sel;
  logic [NUM_GP-1:0]        sel_gp;
  logic                     prot_hit;
  logic                     unlocked;
  logic [NUM_GP-1:0][DW-1:0] gp_q;
  logic [DW-1:0]            susp_q;
  logic [BOOT_W-1:0]        boot_q;
  logic [DW-1:0]            rd_mux;

  // address decode
  assign sel.key_a = (bus_addr == ADDR_W'(OFS_KEY_A));
  assign sel.key_b = (bus_addr == ADDR_W'(OFS_KEY_B));
  assign sel.boot  = (bus_addr == ADDR_W'(OFS_BOOT));
  assign sel.susp  = (bus_addr == ADDR_W'(OFS_SUSP));

  for (genvar i = 0; i < NUM_GP; i++) begin : g_dec
    assign sel_gp[i] = (bus_addr == ADDR_W'(OFS_GP + 4 * i));
  end

  assign prot_hit = sel.susp | (|sel_gp);

  cfg_key_lock u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_key_a (bus_wr & sel.key_a),
    .wr_key_b (bus_wr & sel.key_b),
    .wdata    (bus_wdata),
    .unlocked (unlocked)
  );

  cfg_boot_latch #(.W(BOOT_W)) u_boot (
    .clk    (clk),
    .rst_n  (rst_n),
    .pins   (boot_pins),
    .boot_q (boot_q)
  );

  cfg_reg_store #(.NUM_GP(NUM_GP)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_ok    (bus_wr & unlocked),
    .sel_gp   (sel_gp),
    .sel_susp (sel.susp),
    .wdata    (bus_wdata),
    .gp_q     (gp_q),
    .susp_q   (susp_q)
  );

  // read path: keys and unmapped offsets fall through as zero
  always_comb begin
    rd_mux = '0;
    if (sel.boot) rd_mux = DW'(boot_q);
    if (sel.susp) rd_mux = susp_q;
    for (int i = 0; i < NUM_GP; i++) begin
      if (sel_gp[i]) rd_mux = gp_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  if (ERR_EN) begin : g_err
    always_ff @(posedge clk) begin
      if (!rst_n) wr_blocked <= 1'b0;
      else        wr_blocked <= bus_wr & prot_hit & ~unlocked;
    end
  end else begin : g_noerr
    assign wr_blocked = 1'b0;
  end
endmodule

// File: rtl/keyed_cfg_bank_chk.sv
module keyed_cfg_bank_chk
  import cfgbank_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned BOOT_W = 16,
  parameter bit          ERR_EN = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [DW-1:0]     bus_wdata,
  input logic              bus_rd,
  input logic [DW-1:0]     bus_rdata,
  input logic              wr_blocked,
  input logic              unlocked,
  input logic [DW-1:0]     susp_q,
  input logic [BOOT_W-1:0] boot_q
);
  logic key_a_wr, key_b_wr, key_rd;
  assign key_a_wr = bus_wr && bus_addr == ADDR_W'(OFS_KEY_A);
  assign key_b_wr = bus_wr && bus_addr == ADDR_W'(OFS_KEY_B);
  assign key_rd   = bus_rd && (bus_addr == ADDR_W'(OFS_KEY_A) || bus_addr == ADDR_W'(OFS_KEY_B));

  assert_locked_at_reset_R1: assert property (@(posedge clk)
    !rst_n |=> !unlocked);

  assert_unlock_from_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(key_a_wr || key_b_wr));

  assert_locked_susp_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(OFS_SUSP) && !unlocked) |=> $stable(susp_q));

  assert_bad_key_a_relocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (key_a_wr && bus_wdata != KEY_A_VAL) |=> !unlocked);

  assert_bad_key_b_relocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (key_b_wr && bus_wdata != KEY_B_VAL) |=> !unlocked);

  assert_key_reads_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    key_rd |=> bus_rdata == '0);

  assert_boot_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(boot_q));

  assert_susp_unmasked_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (susp_q & ~SUSP_MASK) == '0);

  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

  assert_blocked_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ERR_EN && bus_wr && !unlocked &&
     (bus_addr == ADDR_W'(OFS_SUSP) || bus_addr == ADDR_W'(OFS_GP))) |=> wr_blocked);

  assert_no_pulse_on_key_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (key_a_wr || key_b_wr) |=> !wr_blocked);
endmodule

bind keyed_cfg_bank keyed_cfg_bank_chk #(
  .ADDR_W (ADDR_W),
  .BOOT_W (BOOT_W),
  .ERR_EN (ERR_EN)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_wr     (bus_wr),
  .bus_wdata  (bus_wdata),
  .bus_rd     (bus_rd),
  .bus_rdata  (bus_rdata),
  .wr_blocked (wr_blocked),
  .unlocked   (unlocked),
  .susp_q     (susp_q),
  .boot_q     (boot_q)
);

// File: tb/test_keyed_cfg_bank.sv
`timescale 1ns/1ps
module test_keyed_cfg_bank;
  localparam int AW = 12;
  localparam int NG = 4;
  localparam int BW = 8;
  localparam logic [31:0] KA = 32'h83E7_0B13;
  localparam logic [31:0] KB = 32'h95A4_F1E0;
  localparam logic [AW-1:0] A_KA = 12'h038, A_KB = 12'h03C, A_BOOT = 12'h020,
                            A_SUSP = 12'h170, A_GP0 = 12'h100, A_NONE = 12'h004;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n = 1'b0;
  logic [BW-1:0] boot_pins = '0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic          bus_rd = 1'b0;
  logic [31:0]   bus_rdata;
  logic          wr_blocked;

  keyed_cfg_bank #(.ADDR_W(AW), .NUM_GP(NG), .BOOT_W(BW), .ERR_EN(1'b1)) i_keyed_cfg_bank (
    .clk(clk), .rst_n(rst_n), .boot_pins(boot_pins), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .wr_blocked(wr_blocked)
  );

  int checks = 0;
  int errors = 0;

  // reference model
  bit            m_ka, m_kb;
  logic [31:0]   m_gp [NG];
  logic [31:0]   m_susp;
  logic [BW-1:0] m_boot;

  function automatic logic [AW-1:0] gp_addr(int i);
    return AW'(12'h100 + 4 * i);
  endfunction

  function automatic bit exp_prot(logic [AW-1:0] a);
    if (a == A_SUSP) return 1'b1;
    for (int i = 0; i < NG; i++) if (a == gp_addr(i)) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [31:0] exp_read(logic [AW-1:0] a);
    if (a == A_BOOT) return 32'(m_boot);
    if (a == A_SUSP) return m_susp;
    for (int i = 0; i < NG; i++) if (a == gp_addr(i)) return m_gp[i];
    return 32'h0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model_reset(logic [BW-1:0] pins);
    m_ka = 1'b0; m_kb = 1'b0;
    m_susp = 32'h0851_0000;
    for (int i = 0; i < NG; i++) m_gp[i] = '0;
    m_boot = pins;
  endtask

  task automatic do_write(logic [AW-1:0] a, logic [31:0] d);
    logic exp_blk;
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
    exp_blk = exp_prot(a) && !(m_ka && m_kb);
    check("R11", 32'(wr_blocked), 32'(exp_blk), "blocked pulse");
    if (exp_prot(a) && m_ka && m_kb) begin
      if (a == A_SUSP) m_susp = d & 32'h0851_0000;
      for (int i = 0; i < NG; i++) if (a == gp_addr(i)) m_gp[i] = d;
    end
    if (a == A_KA) begin
      if (d == KA) m_ka = 1'b1; else begin m_ka = 1'b0; m_kb = 1'b0; end
    end
    if (a == A_KB) begin
      if (d == KB) m_kb = 1'b1; else begin m_ka = 1'b0; m_kb = 1'b0; end
    end
  endtask

  task automatic do_read(logic [AW-1:0] a, string req);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0;
    check(req, bus_rdata, exp_read(a), $sformatf("read @%h", a));
  endtask

  task automatic apply_reset(logic [BW-1:0] pins);
    @(negedge clk);
    rst_n = 1'b0;
    boot_pins = ~pins;
    repeat (2) @(negedge clk);
    boot_pins = pins;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_reset(pins);
    @(negedge clk);
    boot_pins = ~pins;   // later pin changes must not reach the register
  endtask

  task automatic read_all(string req);
    do_read(A_SUSP, req);
    for (int i = 0; i < NG; i++) do_read(gp_addr(i), req);
    do_read(A_BOOT, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [AW-1:0] pick [10];
    void'($urandom(32'd20240611));

    // R1 / R6: reset values and pin capture
    apply_reset(8'hA5);
    check("R1", bus_rdata, 32'h0, "rdata after reset");
    read_all("R1");
    do_read(A_BOOT, "R6");

    // R3: writes while locked are dropped
    do_write(gp_addr(1), 32'hDEAD_BEEF);
    do_write(A_SUSP, 32'h0);
    do_read(gp_addr(1), "R3");
    do_read(A_SUSP, "R3");

    // R6 / R9: boot and unmapped ignore writes
    do_write(A_BOOT, 32'hFFFF_FFFF);
    do_write(A_NONE, 32'h1234_5678);
    do_read(A_BOOT, "R6");
    do_read(A_NONE, "R9");
    do_read(12'h172, "R9");

    // R2: unlock, first key then second
    do_write(A_KA, KA);
    do_write(gp_addr(1), 32'h1111_0000);
    do_read(gp_addr(1), "R3");
    do_write(A_KB, KB);
    do_write(gp_addr(1), 32'hCAFE_F00D);
    do_read(gp_addr(1), "R2");
    do_read(A_KA, "R5");
    do_read(A_KB, "R5");

    // R7: only four suspend bits stored; read-modify-write clears one
    do_write(A_SUSP, 32'hFFFF_FFFF);
    do_read(A_SUSP, "R7");
    check("R7", exp_read(A_SUSP), 32'h0851_0000, "model mask");
    v = bus_rdata & ~32'h0010_0000;
    do_write(A_SUSP, v);
    do_read(A_SUSP, "R7");

    // R8: every general-purpose word
    for (int i = 0; i < NG; i++) do_write(gp_addr(i), 32'hA000_0000 | 32'(i));
    for (int i = 0; i < NG; i++) do_read(gp_addr(i), "R8");

    // R4: wrong key relocks, then second key first, then first key
    do_write(A_KB, 32'h0);
    do_write(gp_addr(0), 32'h5555_5555);
    do_read(gp_addr(0), "R4");
    do_write(A_KA, KA);
    do_write(gp_addr(0), 32'h6666_6666);
    do_read(gp_addr(0), "R4");
    do_write(A_KA, 32'h83E7_0B12);
    do_write(A_KB, KB);
    do_write(gp_addr(0), 32'h7777_7777);
    do_read(gp_addr(0), "R4");
    do_write(A_KA, KA);
    do_write(gp_addr(0), 32'h8888_8888);
    do_read(gp_addr(0), "R2");

    // R10: read data holds while no read is issued
    do_read(gp_addr(2), "R10");
    v = bus_rdata;
    @(negedge clk); bus_addr = A_SUSP;
    repeat (3) @(negedge clk);
    check("R10", bus_rdata, v, "rdata held");

    // random mix
    pick[0] = A_KA; pick[1] = A_KB; pick[2] = A_BOOT; pick[3] = A_SUSP;
    pick[4] = gp_addr(0); pick[5] = gp_addr(1); pick[6] = gp_addr(2);
    pick[7] = gp_addr(NG - 1); pick[8] = A_NONE; pick[9] = 12'h172;
    for (int n = 0; n < 400; n++) begin
      logic [AW-1:0] a;
      logic [31:0] d;
      a = pick[$urandom % 10];
      d = $urandom;
      if (a == A_KA && ($urandom % 2) == 0) d = KA;
      if (a == A_KB && ($urandom % 2) == 0) d = KB;
      if (($urandom % 2) == 0) do_write(a, d);
      else do_read(a, "R8");
    end

    // R1 / R6: reset while open restores locked state and recaptures pins
    do_write(A_KA, KA);
    do_write(A_KB, KB);
    apply_reset(8'h3C);
    read_all("R1");
    do_write(gp_addr(3), 32'hFFFF_0000);
    do_read(gp_addr(3), "R1");
    do_read(A_BOOT, "R6");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule